// File: doc/BRIEF.md
# Max-Pool and Window Unroll Stage

This block sits between two convolution layers of an image classifier. It accepts one image worth of first-layer results: a 576-row by 8-column byte matrix in which each column is a 24x24 feature map stored row by row. Only columns 0 to 5 hold real features; columns 6 and 7 are padding. As the beats arrive, the block reduces each map with a stride-2 2x2 maximum, keeping a 12x12 result per map in one byte-wide memory bank per map.

Once the whole image is in, the block streams out the input of the next 5x5 convolution, one byte per handshake. For each map and each of the 8x8 valid output positions, it sends the 25 pooled bytes under the 5x5 window. Input and output never overlap. The input side refuses beats while the previous image is still being sent, so the pooled store never holds two images at once.

Top module: `pool_unroll`

## Requirements
- R1: After reset, `s_tready` is 1 and `m_tvalid` is 0.
- R2: An input beat carries two matrix rows. Row 2k sits in `s_tdata[63:0]` and row 2k+1 in `s_tdata[127:64]`. Column c of a row is byte c of its 64-bit half (bits 8c+7:8c). Beat k of an image holds rows 2k and 2k+1, and rows are pixel indices y*24+x.
- R3: Pooled value (py,px) of map c is the largest of the four pixels (2py..2py+1, 2px..2px+1) of column c, with bytes compared as signed two's-complement values.
- R4: The values in columns 6 and 7 have no effect on any output byte.
- R5: Output byte number n = (((c*8+oy)*8+ox)*5+ky)*5+kx equals pooled value (oy+ky, ox+kx) of map c. The order runs map first, then output row, output column, window row and window column, the last of these changing fastest.
- R6: Each image produces exactly 9600 output bytes, and `m_tlast` is 1 on the last of them only.
- R7: `s_tready` is 0 while `m_tvalid` is 1. The cycle after the final output handshake, `s_tready` is 1 again and `m_tvalid` is 0.
- R8: While `m_tvalid` is 1 and `m_tready` is 0, the next cycle keeps `m_tvalid` at 1 and holds `m_tdata` and `m_tlast` unchanged.
- R9: The cycle after the 288th accepted input beat of an image, `m_tvalid` is 1 and `s_tready` is 0. Cycles with `s_tvalid` low do not advance the beat count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| s_tdata | input | 128 | Input beat, two matrix rows |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Input beat accepted when high with `s_tvalid` |
| m_tdata | output | 8 | One byte of the unrolled window matrix |
| m_tvalid | output | 1 | Output byte valid |
| m_tready | input | 1 | Downstream accepts the byte |
| m_tlast | output | 1 | Last byte of the image |

## Verification
Two events can fall in the same cycle. The last input beat completes both the pooling of entry 143 and the switch to output, and the first output byte is then read in the very next cycle. Likewise, the final output handshake coincides with the return of `s_tready`. The bench drives images with random gaps on `s_tvalid` and random stalls on `m_tready`. It checks the port values on the falling edge right after each of these boundary cycles. It also compares every output byte against a pooled matrix the bench computes itself, using extreme signed values and an image whose padding columns are forced to the largest positive byte.

// File: rtl/pool_unroll_pkg.sv
// Shared helpers for the pooling and window unroll stage.
package pool_unroll_pkg;

    localparam int BYTE_W = 8;

    // Larger of two bytes taken as signed two's-complement values.
    function automatic logic [BYTE_W-1:0] smax8(input logic [BYTE_W-1:0] a,
                                                input logic [BYTE_W-1:0] b);
        return ($signed(a) > $signed(b)) ? a : b;
    endfunction

endpackage

// File: rtl/pool_capture.sv
// Consumes input beats of two horizontally adjacent pixels and pools on the fly.
// Assumes IMG_DIM is even, so both rows of a beat share one image line, and
// that a beat only arrives while the caller holds beat_fire. Even lines are
// kept as pair maxima in a line buffer; odd lines finish each 2x2 block and
// issue a write of all map bytes for that pooled position.
module pool_capture
    import pool_unroll_pkg::*;
#(
    parameter int IMG_DIM = 24,
    parameter int N_COLS  = 8,
    parameter int N_MAPS  = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          beat_fire,
    input  logic [2*N_COLS*BYTE_W-1:0]    beat_data,
    output logic                          wr_en,
    output logic [$clog2((IMG_DIM/2)*(IMG_DIM/2))-1:0] wr_addr,
    output logic [N_MAPS*BYTE_W-1:0]      wr_data,
    output logic                          img_done
);
    localparam int POOL_DIM = IMG_DIM / 2;
    localparam int ROW_W    = N_COLS * BYTE_W;
    localparam int DW       = N_MAPS * BYTE_W;
    localparam int AW       = $clog2(POOL_DIM * POOL_DIM);
    localparam int XW       = $clog2(POOL_DIM);
    localparam int YW       = $clog2(IMG_DIM);
    localparam int PW       = (N_COLS - N_MAPS) * BYTE_W;

    logic [XW-1:0] xq;
    logic [YW-1:0] yq;
    logic [DW-1:0] line_q [POOL_DIM];
    logic [DW-1:0] pair_max;
    logic          last_col;
    logic          last_row;

    // Per map: horizontal pair maximum, then vertical maximum with the line buffer.
    for (genvar c = 0; c < N_MAPS; c++) begin : g_map
        assign pair_max[c*BYTE_W +: BYTE_W] =
            smax8(beat_data[c*BYTE_W +: BYTE_W], beat_data[ROW_W + c*BYTE_W +: BYTE_W]);
        assign wr_data[c*BYTE_W +: BYTE_W] =
            smax8(pair_max[c*BYTE_W +: BYTE_W], line_q[xq][c*BYTE_W +: BYTE_W]);
    end

    // Padding columns are dropped here and reach no logic.
    if (PW > 0) begin : g_pad
        logic [2*PW-1:0] unused_pad;
        assign unused_pad = {beat_data[2*ROW_W-1 -: PW], beat_data[ROW_W-1 -: PW]};
    end

    assign last_col = (xq == XW'(POOL_DIM - 1));
    assign last_row = (yq == YW'(IMG_DIM - 1));
    assign wr_en    = beat_fire & yq[0];
    assign wr_addr  = AW'((int'(yq) / 2) * POOL_DIM + int'(xq));
    assign img_done = beat_fire & last_col & last_row;

    // Track pixel pair column and image line of the next beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xq <= '0;
            yq <= '0;
        end else if (beat_fire) begin
            if (last_col) begin
                xq <= '0;
                yq <= last_row ? '0 : yq + 1'b1;
            end else begin
                xq <= xq + 1'b1;
            end
        end
    end

    // Hold pair maxima of an even line until the odd line below arrives.
    always_ff @(posedge clk) begin
        if (beat_fire && !yq[0]) begin
            line_q[xq] <= pair_max;
        end
    end

endmodule

// File: rtl/pool_bank_store.sv
// Pooled map storage: one byte-wide bank per feature map.
// All banks are written together at one pooled position; a read selects
// one bank and one position, with the data available in the same cycle.
module pool_bank_store
    import pool_unroll_pkg::*;
#(
    parameter int N_MAPS   = 6,
    parameter int POOL_PIX = 144
) (
    input  logic                        clk,
    input  logic                        wr_en,
    input  logic [$clog2(POOL_PIX)-1:0] wr_addr,
    input  logic [N_MAPS*BYTE_W-1:0]    wr_data,
    input  logic [$clog2(N_MAPS)-1:0]   rd_map,
    input  logic [$clog2(POOL_PIX)-1:0] rd_addr,
    output logic [BYTE_W-1:0]           rd_byte
);
    localparam int MW = $clog2(N_MAPS);

    logic [BYTE_W-1:0] rd_each [N_MAPS];

    for (genvar c = 0; c < N_MAPS; c++) begin : g_bank
        logic [BYTE_W-1:0] bank [POOL_PIX];

        // Store this map's byte of a finished pooled position.
        always_ff @(posedge clk) begin
            if (wr_en) begin
                bank[wr_addr] <= wr_data[c*BYTE_W +: BYTE_W];
            end
        end

        assign rd_each[c] = bank[rd_addr];
    end

    // Pick the bank of the map being sent.
    always_comb begin
        rd_byte = '0;
        for (int c = 0; c < N_MAPS; c++) begin
            if (rd_map == MW'(c)) begin
                rd_byte = rd_each[c];
            end
        end
    end

endmodule

// File: rtl/window_walker.sv
// Steps through the unrolled window matrix: map, output row, output column,
// window row, window column (fastest). Produces the pooled address under the
// current window tap and flags the final byte. Assumes the counters start at
// zero; they wrap back to zero on the step that leaves the final byte.
module window_walker #(
    parameter int N_MAPS   = 6,
    parameter int POOL_DIM = 12,
    parameter int KDIM     = 5
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   step,
    output logic [$clog2(N_MAPS)-1:0]              map_idx,
    output logic [$clog2(POOL_DIM*POOL_DIM)-1:0]   rd_addr,
    output logic                                   last
);
    localparam int OUT_DIM = POOL_DIM - KDIM + 1;
    localparam int AW      = $clog2(POOL_DIM * POOL_DIM);
    localparam int KW      = $clog2(KDIM);
    localparam int OW      = $clog2(OUT_DIM);
    localparam int MW      = $clog2(N_MAPS);

    logic [KW-1:0] kx, ky;
    logic [OW-1:0] ox, oy;
    logic [MW-1:0] mp;
    logic          kx_w, ky_w, ox_w, oy_w, mp_w;

    assign kx_w    = (kx == KW'(KDIM - 1));
    assign ky_w    = (ky == KW'(KDIM - 1));
    assign ox_w    = (ox == OW'(OUT_DIM - 1));
    assign oy_w    = (oy == OW'(OUT_DIM - 1));
    assign mp_w    = (mp == MW'(N_MAPS - 1));
    assign last    = kx_w & ky_w & ox_w & oy_w & mp_w;
    assign map_idx = mp;
    assign rd_addr = AW'((int'(oy) + int'(ky)) * POOL_DIM + int'(ox) + int'(kx));

    // Advance the nested position counters on each accepted output byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kx <= '0;
            ky <= '0;
            ox <= '0;
            oy <= '0;
            mp <= '0;
        end else if (step) begin
            if (!kx_w) begin
                kx <= kx + 1'b1;
            end else begin
                kx <= '0;
                if (!ky_w) begin
                    ky <= ky + 1'b1;
                end else begin
                    ky <= '0;
                    if (!ox_w) begin
                        ox <= ox + 1'b1;
                    end else begin
                        ox <= '0;
                        if (!oy_w) begin
                            oy <= oy + 1'b1;
                        end else begin
                            oy <= '0;
                            mp <= mp_w ? '0 : mp + 1'b1;
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/pool_unroll.sv
// Top of the pooling and window unroll stage. Alternates between a capture
// phase (input open, pooling as beats arrive) and an emit phase (input
// closed, window bytes streamed). Assumes a whole image is
// IMG_DIM*IMG_DIM/2 input beats.
module pool_unroll
    import pool_unroll_pkg::*;
#(
    parameter int IMG_DIM = 24,
    parameter int N_COLS  = 8,
    parameter int N_MAPS  = 6,
    parameter int KDIM    = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [2*N_COLS*BYTE_W-1:0] s_tdata,
    input  logic                       s_tvalid,
    output logic                       s_tready,
    output logic [BYTE_W-1:0]          m_tdata,
    output logic                       m_tvalid,
    input  logic                       m_tready,
    output logic                       m_tlast
);
    localparam int POOL_DIM = IMG_DIM / 2;
    localparam int POOL_PIX = POOL_DIM * POOL_DIM;
    localparam int AW       = $clog2(POOL_PIX);
    localparam int MW       = $clog2(N_MAPS);

    typedef enum logic {PH_CAPTURE, PH_EMIT} phase_t;

    phase_t                   phase_q;
    logic                     beat_fire, out_fire;
    logic                     wr_en, img_done, walk_last;
    logic [AW-1:0]            wr_addr, rd_addr;
    logic [N_MAPS*BYTE_W-1:0] wr_data;
    logic [MW-1:0]            rd_map;

    assign s_tready  = (phase_q == PH_CAPTURE);
    assign m_tvalid  = (phase_q == PH_EMIT);
    assign beat_fire = s_tvalid & s_tready;
    assign out_fire  = m_tvalid & m_tready;
    assign m_tlast   = m_tvalid & walk_last;

    // Switch phase at the end of capture and at the end of emission.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_CAPTURE;
        end else if (phase_q == PH_CAPTURE && img_done) begin
            phase_q <= PH_EMIT;
        end else if (out_fire && walk_last) begin
            phase_q <= PH_CAPTURE;
        end
    end

    pool_capture #(
        .IMG_DIM (IMG_DIM),
        .N_COLS  (N_COLS),
        .N_MAPS  (N_MAPS)
    ) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .beat_fire (beat_fire),
        .beat_data (s_tdata),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .img_done  (img_done)
    );

    pool_bank_store #(
        .N_MAPS   (N_MAPS),
        .POOL_PIX (POOL_PIX)
    ) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_map  (rd_map),
        .rd_addr (rd_addr),
        .rd_byte (m_tdata)
    );

    window_walker #(
        .N_MAPS   (N_MAPS),
        .POOL_DIM (POOL_DIM),
        .KDIM     (KDIM)
    ) u_walker (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (out_fire),
        .map_idx (rd_map),
        .rd_addr (rd_addr),
        .last    (walk_last)
    );

endmodule

// File: rtl/pool_unroll_chk.sv
// Port-level protocol checker for pool_unroll, attached by bind.
// Keeps its own counts of accepted input beats and output bytes.
module pool_unroll_chk #(
    parameter int IMG_DIM = 24,
    parameter int N_MAPS  = 6,
    parameter int KDIM    = 5
) (
    input logic       clk,
    input logic       rst_n,
    input logic       s_tvalid,
    input logic       s_tready,
    input logic [7:0] m_tdata,
    input logic       m_tvalid,
    input logic       m_tready,
    input logic       m_tlast
);
    localparam int BEATS   = IMG_DIM * IMG_DIM / 2;
    localparam int OUT_DIM = IMG_DIM / 2 - KDIM + 1;
    localparam int TOTAL   = N_MAPS * OUT_DIM * OUT_DIM * KDIM * KDIM;

    int in_cnt;
    int out_cnt;

    // Count accepted beats and bytes within the current image.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_cnt  <= 0;
            out_cnt <= 0;
        end else begin
            if (s_tvalid && s_tready) in_cnt  <= (in_cnt == BEATS - 1) ? 0 : in_cnt + 1;
            if (m_tvalid && m_tready) out_cnt <= (out_cnt == TOTAL - 1) ? 0 : out_cnt + 1;
        end
    end

    a_r7_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_tready && m_tvalid));

    a_r7_reopen: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && m_tready && m_tlast) |=> (s_tready && !m_tvalid));

    a_r9_switch: assert property (@(posedge clk) disable iff (!rst_n)
        (s_tvalid && s_tready && in_cnt == BEATS - 1) |=> (m_tvalid && !s_tready));

    a_r6_last_pos: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> (m_tlast == (out_cnt == TOTAL - 1)));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

endmodule

bind pool_unroll pool_unroll_chk #(
    .IMG_DIM (IMG_DIM),
    .N_MAPS  (N_MAPS),
    .KDIM    (KDIM)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_tvalid (s_tvalid),
    .s_tready (s_tready),
    .m_tdata  (m_tdata),
    .m_tvalid (m_tvalid),
    .m_tready (m_tready),
    .m_tlast  (m_tlast)
);

// File: tb/pool_unroll_bench.sv
`timescale 1ns/1ps
module pool_unroll_bench;
    localparam int IMG  = 24;
    localparam int NC   = 8;
    localparam int NM   = 6;
    localparam int KD   = 5;
    localparam int OD   = IMG / 2 - KD + 1;
    localparam int NB   = IMG * IMG / 2;
    localparam int NOUT = NM * OD * OD * KD * KD;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [127:0]   s_tdata;
    logic           s_tvalid;
    logic           s_tready;
    logic [7:0]     m_tdata;
    logic           m_tvalid;
    logic           m_tready;
    logic           m_tlast;

    int n_checks = 0;
    int n_fail   = 0;
    logic [63:0] rows [IMG*IMG];

    always #2 clk = ~clk;

    pool_unroll u_pool_unroll (
        .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
        .s_tready(s_tready), .m_tdata(m_tdata), .m_tvalid(m_tvalid),
        .m_tready(m_tready), .m_tlast(m_tlast)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Signed 2x2 maximum of column m at pooled position (py,px).
    function automatic logic [7:0] pooled(input int m, input int py, input int px);
        logic signed [7:0] best, v;
        best = $signed(rows[(2*py)*IMG + 2*px][8*m +: 8]);
        for (int dy = 0; dy < 2; dy++) begin
            for (int dx = 0; dx < 2; dx++) begin
                v = $signed(rows[(2*py+dy)*IMG + 2*px+dx][8*m +: 8]);
                if (v > best) best = v;
            end
        end
        return best;
    endfunction

    // Output byte n: map, out row, out col, window row, window col.
    function automatic logic [7:0] expected(input int n);
        int kx, ky, ox, oy, m;
        kx = n % KD;
        ky = (n / KD) % KD;
        ox = (n / (KD*KD)) % OD;
        oy = (n / (KD*KD*OD)) % OD;
        m  = n / (KD*KD*OD*OD);
        return pooled(m, oy + ky, ox + kx);
    endfunction

    // mode 0: random, 1: extreme signed values, 2: keep maps, pads at +127
    task automatic fill(input int mode);
        logic [7:0] ext [6];
        ext = '{8'h80, 8'h7F, 8'hFF, 8'h00, 8'h01, 8'h81};
        for (int r = 0; r < IMG*IMG; r++) begin
            for (int c = 0; c < NC; c++) begin
                case (mode)
                    0: rows[r][8*c +: 8] = 8'($urandom);
                    1: rows[r][8*c +: 8] = ext[$urandom_range(0, 5)];
                    default: if (c >= NM) rows[r][8*c +: 8] = 8'h7F;
                endcase
            end
        end
    endtask

    // Send one image, then collect and judge its output.
    task automatic run_image(input string req, input int gap_pct, input int stall_pct);
        int k, n;
        bit prev_stall;
        logic [7:0] prev_data;
        logic prev_last;
        k = 0;
        while (k < NB) begin
            @(negedge clk);
            if ($urandom_range(0, 99) < gap_pct) begin
                s_tvalid = 1'b0;
            end else begin
                s_tvalid = 1'b1;
                s_tdata  = {rows[2*k+1], rows[2*k]};
            end
            if (k == 0 || s_tvalid)
                check(m_tvalid == 1'b0, "R7", "m_tvalid during capture", int'(m_tvalid), 0);
            if (s_tvalid && s_tready) k++;
        end
        @(negedge clk);
        s_tvalid = 1'b0;
        check(m_tvalid == 1'b1, "R9", "m_tvalid after last beat", int'(m_tvalid), 1);
        check(s_tready == 1'b0, "R9", "s_tready after last beat", int'(s_tready), 0);
        n = 0;
        prev_stall = 1'b0;
        prev_data  = '0;
        prev_last  = 1'b0;
        while (n < NOUT) begin
            m_tready = ($urandom_range(0, 99) >= stall_pct);
            if (prev_stall) begin
                check(m_tvalid && m_tdata == prev_data && m_tlast == prev_last, "R8",
                      "held byte under stall", int'(m_tdata), int'(prev_data));
            end
            if (m_tvalid && m_tready) begin
                check(m_tdata == expected(n), req, $sformatf("byte %0d", n),
                      int'(m_tdata), int'(expected(n)));
                check(m_tlast == (n == NOUT - 1), "R6", $sformatf("tlast at %0d", n),
                      int'(m_tlast), int'(n == NOUT - 1));
                check(s_tready == 1'b0, "R7", "s_tready during output", int'(s_tready), 0);
                n++;
            end
            prev_stall = m_tvalid && !m_tready;
            prev_data  = m_tdata;
            prev_last  = m_tlast;
            @(negedge clk);
        end
        m_tready = 1'b0;
        check(s_tready == 1'b1, "R7", "s_tready after final byte", int'(s_tready), 1);
        check(m_tvalid == 1'b0, "R6", "no byte beyond 9600", int'(m_tvalid), 0);
    endtask

    initial begin
        int seed_set;
        seed_set = $urandom(32'h5EED);
        rst_n    = 1'b0;
        s_tvalid = 1'b0;
        s_tdata  = '0;
        m_tready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check(s_tready == 1'b1, "R1", "s_tready after reset", int'(s_tready), 1);
        check(m_tvalid == 1'b0, "R1", "m_tvalid after reset", int'(m_tvalid), 0);
        fill(1);
        run_image("R3", 30, 30);
        fill(0);
        run_image("R5", 25, 40);
        fill(2);
        run_image("R4", 0, 0);
        fill(0);
        run_image("R2", 50, 10);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule